// File: doc/BRIEF.md
# Nested Vectored Interrupt Sequencer

This block decides which exception a core takes next and in which order. It accepts a reset request, a non-maskable request and a set of interrupt request lines, each line with a priority that can be written at run time. A one-cycle pulse on any request records it as pending. The arbiter picks the most urgent pending request, and the sequencer then walks through a timed save phase, the handler start and a timed restore phase. It drives the vector index of the chosen source to a fetch unit. The index is taken straight from the source number, so no shared handler and no polling are needed.

A small stack of the active levels holds the nesting. A more urgent request interrupts the running handler, and the interrupted handler continues once the new one completes. Two ways of saving time are built in. First, when a handler finishes and a waiting request is eligible, the next handler starts at once, with no restore and no new save. Second, a more urgent request that arrives while the save phase runs takes over the vector, and the request it displaced follows later. A restore phase that is in progress is dropped if an eligible request turns up during it. Memory traffic and the pipeline are not modelled; they appear only as phases of fixed length.

Top module: `nvs_seq`

## Requirements
- R1: Each source has a level, and a lower level is more urgent. Reset sits at level 0 and NMI at level 1. Interrupt line i sits at level (priority register i + 2). A write with prio_we high loads prio_wdata into register prio_sel at the next edge, and the new value applies from then on. Registers reset to 0.
- R2: The vector index is the source number plus 1: reset gives 1, NMI gives 2 and interrupt line i gives 3+i.
- R3: A one-cycle pulse on a request input sets that source's pending flag. The flag clears when the handler of that source starts, so every handler_start matches exactly one request.
- R4: cur_level shows the level of the running handler. It reads 15 (all ones) when no handler is active. A pending request strictly more urgent than cur_level starts the save phase.
- R5: The save phase keeps stacking high for exactly STACK_CYC cycles (default 8). In the cycle after it ends, handler_start pulses for one cycle, with vec_valid high and vec_idx set to the vector of the handler.
- R6: A pending request of equal or lower urgency than cur_level causes no save phase and stays pending.
- R7: Among pending requests of equal level, the lowest source number wins (reset 0, NMI 1, line i is source 2+i).
- R8: When handler_done arrives and no pending request is eligible, unstacking is high for exactly UNSTACK_CYC cycles (default 8), with vec_valid low. After that, cur_level and vec_idx are those of the interrupted handler, or cur_level is 15 if there is none.
- R9: When handler_done arrives and a pending request is more urgent than the level that would be resumed, handler_start for that request pulses in the very next cycle, and unstacking stays low.
- R10: If a strictly more urgent request becomes pending during the save phase, that phase still lasts STACK_CYC cycles in total but starts the new request's handler. The displaced request starts later through a handler_start that needs no second save phase.
- R11: If an eligible request becomes pending during the restore phase, that phase ends early and the new handler starts in the cycle after the request is recorded.
- R12: handler_done while no handler is active has no effect: no restore phase, and cur_level stays 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_req | input | 1 | Reset exception request pulse |
| nmi_req | input | 1 | Non-maskable request pulse |
| irq_req | input | N_IRQ | Interrupt request pulses, one per line |
| prio_we | input | 1 | Priority register write enable |
| prio_sel | input | $clog2(N_IRQ) | Line whose priority is written |
| prio_wdata | input | PRIO_W | Priority value to write |
| handler_done | input | 1 | Running handler has finished |
| vec_valid | output | 1 | vec_idx is meaningful |
| vec_idx | output | VEC_W | Vector being fetched or running |
| stacking | output | 1 | Save phase in progress |
| unstacking | output | 1 | Restore phase in progress |
| handler_start | output | 1 | First handler cycle, one-cycle pulse |
| cur_level | output | PRIO_W+1 | Level of the running handler, all ones if none |

## Verification
The bench goes after the timing corners where a wrong sequencer still looks busy. A late arrival injected partway through the save phase is one such corner: a design that restarts the phase would stretch stacking past eight cycles, and one that ignores the arrival would start the wrong vector. Tail-chains are driven from the done strobe and from the middle of a restore phase. A design that always restores would show unstacking high, or would start the handler several cycles late. Nested returns with a lower-urgency request waiting check that the resumed level comes from the nesting stack, not from the thread level. Equal-level collisions and a done strobe in thread state catch a wrong tie order and a stack underflow.

// File: rtl/nvs_pkg.sv
// Shared types for the interrupt sequencer.
package nvs_pkg;
    // Sequencer phase: running code, saving context, restoring context.
    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_STACK   = 2'd1,
        ST_UNSTACK = 2'd2
    } seq_state_t;
endpackage

// File: rtl/nvs_prio_regs.sv
// Per-source urgency levels. Source 0 is reset (level 0), source 1 is NMI
// (level 1), source 2+i is interrupt line i at (programmed priority + 2).
// Assumes LW = PRIO_W + 1, so every level stays below the all-ones value.
module nvs_prio_regs #(
    parameter int N_IRQ  = 8,
    parameter int PRIO_W = 3,
    localparam int LW    = PRIO_W + 1,
    localparam int NSRC  = N_IRQ + 2,
    localparam int PSW   = (N_IRQ > 1) ? $clog2(N_IRQ) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [PSW-1:0]            sel,
    input  logic [PRIO_W-1:0]         wdata,
    output logic [NSRC-1:0][LW-1:0]   levels
);
    assign levels[0] = LW'(0);
    assign levels[1] = LW'(1);

    for (genvar i = 0; i < N_IRQ; i++) begin : g_line
        logic [PRIO_W-1:0] prio_q;
        // Holds the programmed priority of line i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio_q <= '0;
            else if (we && (int'(sel) == i))
                prio_q <= wdata;
        end
        assign levels[i+2] = LW'(prio_q) + LW'(2);
    end
endmodule

// File: rtl/nvs_arbiter.sv
// Picks the most urgent pending source; on equal levels the lower source
// number wins. Purely combinational.
module nvs_arbiter #(
    parameter int NSRC = 10,
    parameter int LW   = 4,
    localparam int SW  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]           pend,
    input  logic [NSRC-1:0][LW-1:0]   levels,
    output logic                      best_valid,
    output logic [SW-1:0]             best_src,
    output logic [LW-1:0]             best_lvl
);
    // Scan upward, replacing only on strictly more urgent, so ties keep the lower index.
    always_comb begin
        best_valid = 1'b0;
        best_src   = '0;
        best_lvl   = '1;
        for (int i = 0; i < NSRC; i++) begin
            if (pend[i] && (!best_valid || levels[i] < best_lvl)) begin
                best_valid = 1'b1;
                best_src   = SW'(i);
                best_lvl   = levels[i];
            end
        end
    end
endmodule

// File: rtl/nvs_level_stack.sv
// Nesting stack of active handlers (vector and level). Supports push, pop
// and replace-top. Reports the top level and the level beneath it, using
// all ones for "no handler". Assumes callers never overflow or underflow.
module nvs_level_stack #(
    parameter int DEPTH = 10,
    parameter int VW    = 8,
    parameter int LW    = 4,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic           pop,
    input  logic           repl,
    input  logic [VW-1:0]  in_vec,
    input  logic [LW-1:0]  in_lvl,
    output logic [VW-1:0]  top_vec,
    output logic [LW-1:0]  top_lvl,
    output logic [LW-1:0]  below_lvl,
    output logic [DW-1:0]  depth
);
    logic [VW-1:0] vec_q [DEPTH];
    logic [LW-1:0] lvl_q [DEPTH];
    int unsigned   d;

    assign d = int'(depth);

    // Writes entries and moves the depth pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                vec_q[i] <= '0;
                lvl_q[i] <= '1;
            end
        end else if (push && d < DEPTH) begin
            vec_q[d] <= in_vec;
            lvl_q[d] <= in_lvl;
            depth    <= depth + DW'(1);
        end else if (repl && d != 0) begin
            vec_q[d-1] <= in_vec;
            lvl_q[d-1] <= in_lvl;
        end else if (pop && d != 0) begin
            depth <= depth - DW'(1);
        end
    end

    // Reads the top and second entries.
    always_comb begin
        top_vec   = (d != 0) ? vec_q[d-1] : '0;
        top_lvl   = (d != 0) ? lvl_q[d-1] : '1;
        below_lvl = (d > 1)  ? lvl_q[d-2] : '1;
    end

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (d < DEPTH));
    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop || repl) |-> (d != 0));
endmodule

// File: rtl/nvs_seq.sv
// Interrupt sequencer top. Records request pulses as pending and arbitrates
// among them. Runs timed save and restore phases, with preemption,
// tail-chaining, late arrival and abandoned restore. Assumes handler_done
// is only meaningful while a handler runs (state RUN with depth > 0).
module nvs_seq #(
    parameter int N_IRQ       = 8,
    parameter int PRIO_W      = 3,
    parameter int STACK_CYC   = 8,
    parameter int UNSTACK_CYC = 8,
    parameter int VEC_W       = 8,
    localparam int LW   = PRIO_W + 1,
    localparam int NSRC = N_IRQ + 2,
    localparam int SW   = $clog2(NSRC),
    localparam int PSW  = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
    localparam int CMAX = (STACK_CYC > UNSTACK_CYC) ? STACK_CYC : UNSTACK_CYC,
    localparam int CW   = $clog2(CMAX + 1),
    localparam int DW   = $clog2(NSRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rst_req,
    input  logic               nmi_req,
    input  logic [N_IRQ-1:0]   irq_req,
    input  logic               prio_we,
    input  logic [PSW-1:0]     prio_sel,
    input  logic [PRIO_W-1:0]  prio_wdata,
    input  logic               handler_done,
    output logic               vec_valid,
    output logic [VEC_W-1:0]   vec_idx,
    output logic               stacking,
    output logic               unstacking,
    output logic               handler_start,
    output logic [LW-1:0]      cur_level
);
    import nvs_pkg::*;

    seq_state_t             st, st_n;
    logic [CW-1:0]          cnt, cnt_n;
    logic [SW-1:0]          sel, sel_n, new_src;
    logic [NSRC-1:0]        pend, clr;
    logic [NSRC-1:0][LW-1:0] levels;
    logic                   best_valid, start_n, push, pop, repl;
    logic [SW-1:0]          best_src;
    logic [LW-1:0]          best_lvl, top_lvl, below_lvl, sel_lvl;
    logic [VEC_W-1:0]       top_vec;
    logic [DW-1:0]          depth;

    nvs_prio_regs #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_prio (
        .clk(clk), .rst_n(rst_n), .we(prio_we), .sel(prio_sel),
        .wdata(prio_wdata), .levels(levels));

    nvs_arbiter #(.NSRC(NSRC), .LW(LW)) u_arb (
        .pend(pend), .levels(levels), .best_valid(best_valid),
        .best_src(best_src), .best_lvl(best_lvl));

    nvs_level_stack #(.DEPTH(NSRC), .VW(VEC_W), .LW(LW)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .repl(repl),
        .in_vec(VEC_W'(new_src) + VEC_W'(1)), .in_lvl(levels[new_src]),
        .top_vec(top_vec), .top_lvl(top_lvl), .below_lvl(below_lvl),
        .depth(depth));

    assign sel_lvl = levels[sel];

    // Records request pulses and clears the flag of the source being started.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~clr) | {irq_req, nmi_req, rst_req};
    end

    // Decides the next phase and the stack operation for this cycle.
    always_comb begin
        st_n    = st;
        cnt_n   = cnt;
        sel_n   = sel;
        start_n = 1'b0;
        push    = 1'b0;
        pop     = 1'b0;
        repl    = 1'b0;
        clr     = '0;
        new_src = best_src;
        unique case (st)
            ST_RUN: begin
                if (handler_done && depth != '0) begin
                    if (best_valid && best_lvl < below_lvl) begin
                        repl         = 1'b1;
                        start_n      = 1'b1;
                        clr[best_src] = 1'b1;
                    end else begin
                        pop   = 1'b1;
                        st_n  = ST_UNSTACK;
                        cnt_n = CW'(UNSTACK_CYC - 1);
                    end
                end else if (best_valid && best_lvl < top_lvl) begin
                    st_n  = ST_STACK;
                    sel_n = best_src;
                    cnt_n = CW'(STACK_CYC - 1);
                end
            end
            ST_STACK: begin
                new_src = (best_valid && best_lvl < sel_lvl) ? best_src : sel;
                sel_n   = new_src;
                if (cnt == '0) begin
                    push         = 1'b1;
                    start_n      = 1'b1;
                    clr[new_src] = 1'b1;
                    st_n         = ST_RUN;
                end else begin
                    cnt_n = cnt - CW'(1);
                end
            end
            ST_UNSTACK: begin
                if (best_valid && best_lvl < top_lvl) begin
                    push          = 1'b1;
                    start_n       = 1'b1;
                    clr[best_src] = 1'b1;
                    st_n          = ST_RUN;
                end else if (cnt == '0) begin
                    st_n = ST_RUN;
                end else begin
                    cnt_n = cnt - CW'(1);
                end
            end
            default: st_n = ST_RUN;
        endcase
    end

    // Holds the phase, the phase counter, the selected source and the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= ST_RUN;
            cnt           <= '0;
            sel           <= '0;
            handler_start <= 1'b0;
        end else begin
            st            <= st_n;
            cnt           <= cnt_n;
            sel           <= sel_n;
            handler_start <= start_n;
        end
    end

    assign stacking   = (st == ST_STACK);
    assign unstacking = (st == ST_UNSTACK);
    assign vec_valid  = stacking || (st == ST_RUN && depth != '0);
    assign vec_idx    = stacking ? (VEC_W'(sel) + VEC_W'(1)) : top_vec;
    assign cur_level  = top_lvl;

    p_start_has_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
        handler_start |-> vec_valid);
    p_stack_then_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stacking) |-> handler_start);
    p_preempt_urgent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stacking) |-> (sel_lvl < cur_level));
    p_late_only_upgrades_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stacking && $past(stacking) && !$past(prio_we)) |-> (sel_lvl <= $past(sel_lvl)));
    p_idle_done_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (handler_done && !vec_valid && !stacking && !unstacking) |=> (cur_level == '1));
endmodule

// File: tb/sim_nvs_seq.sv
module sim_nvs_seq;
    localparam int ST_CYC = 8;
    localparam int UN_CYC = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rst_req = 1'b0, nmi_req = 1'b0;
    logic [7:0] irq_req = '0;
    logic       prio_we = 1'b0;
    logic [2:0] prio_sel = '0;
    logic [2:0] prio_wdata = '0;
    logic       handler_done = 1'b0;
    logic       vec_valid, stacking, unstacking, handler_start;
    logic [7:0] vec_idx;
    logic [3:0] cur_level;

    int checks = 0;
    int errors = 0;
    int exp_q[$];

    always #4 clk = ~clk;

    nvs_seq u0 (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .nmi_req(nmi_req),
        .irq_req(irq_req), .prio_we(prio_we), .prio_sel(prio_sel),
        .prio_wdata(prio_wdata), .handler_done(handler_done),
        .vec_valid(vec_valid), .vec_idx(vec_idx), .stacking(stacking),
        .unstacking(unstacking), .handler_start(handler_start),
        .cur_level(cur_level));

    function automatic void chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endfunction

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_prio(int line, int p);
        prio_we = 1'b1; prio_sel = 3'(line); prio_wdata = 3'(p);
        tick(1);
        prio_we = 1'b0;
    endtask

    task automatic pulse(logic r, logic n, logic [7:0] m);
        rst_req = r; nmi_req = n; irq_req = m;
        tick(1);
        rst_req = 1'b0; nmi_req = 1'b0; irq_req = '0;
    endtask

    task automatic done();
        handler_done = 1'b1;
        tick(1);
        handler_done = 1'b0;
    endtask

    task automatic expect_vec(int v);
        exp_q.push_back(v);
    endtask

    task automatic wait_start(output int n);
        n = 0;
        do begin tick(1); n++; end while (!handler_start && n < 100);
    endtask

    task automatic wait_quiet();
        int n = 0;
        do begin tick(1); n++; end while ((stacking || unstacking) && n < 100);
    endtask

    // Monitor: scoreboard for handler starts and phase lengths.
    initial begin
        int srun = 0, urun = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (handler_start) begin
                    if (exp_q.size() == 0) begin
                        chk("R3 unexpected handler_start vector", int'(vec_idx), 0);
                    end else begin
                        chk("R2 start vector", int'(vec_idx), exp_q.pop_front());
                    end
                end
                if (stacking) srun++;
                else if (srun != 0) begin
                    chk("R5 save phase length", srun, ST_CYC);
                    srun = 0;
                end
                if (unstacking) urun++;
                else if (urun != 0) begin
                    if (!handler_start) chk("R8 restore phase length", urun, UN_CYC);
                    urun = 0;
                end
            end
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (100000) @(negedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R4 reset cur_level", int'(cur_level), 15);
        chk("R4 reset vec_valid", int'(vec_valid), 0);
        chk("R5 reset stacking", int'(stacking), 0);
        chk("R8 reset unstacking", int'(unstacking), 0);

        wr_prio(0, 5); wr_prio(1, 3); wr_prio(2, 3); wr_prio(3, 1); wr_prio(4, 6);

        // Single request: full save, run, full restore.
        expect_vec(3);
        pulse(0, 0, 8'h01);
        wait_start(n);
        chk("R1 line0 level", int'(cur_level), 7);
        chk("R5 vec_valid at start", int'(vec_valid), 1);
        tick(2);
        done();
        chk("R8 restore after done", int'(unstacking), 1);
        chk("R8 vec_valid low in restore", int'(vec_valid), 0);
        wait_quiet();
        chk("R8 back to thread", int'(cur_level), 15);

        // Preemption, nesting return and tail-chain into a waiting request.
        expect_vec(3);
        pulse(0, 0, 8'h01);
        wait_start(n);
        expect_vec(6);
        pulse(0, 0, 8'h08);
        wait_start(n);
        chk("R4 preempting level", int'(cur_level), 3);
        pulse(0, 0, 8'h10);
        tick(3);
        chk("R6 no save for less urgent", int'(stacking), 0);
        chk("R6 level unchanged", int'(cur_level), 3);
        done();
        chk("R8 restore to preempted", int'(unstacking), 1);
        wait_quiet();
        chk("R8 resumed vector", int'(vec_idx), 3);
        chk("R8 resumed level", int'(cur_level), 7);
        expect_vec(7);
        done();
        chk("R9 tail-chain start", int'(handler_start), 1);
        chk("R9 no restore on tail-chain", int'(unstacking), 0);
        done();
        wait_quiet();

        // Equal-level collision: lower line first, then tail-chain.
        expect_vec(4);
        expect_vec(5);
        pulse(0, 0, 8'h06);
        wait_start(n);
        chk("R7 tie winner", int'(vec_idx), 4);
        done();
        chk("R9 tie loser tail-chains", int'(handler_start), 1);
        done();
        wait_quiet();

        // Late arrival during the save phase.
        expect_vec(6);
        expect_vec(3);
        pulse(0, 0, 8'h01);
        n = 0;
        while (!stacking && n < 20) begin tick(1); n++; end
        tick(2);
        pulse(0, 0, 8'h08);
        wait_start(n);
        chk("R10 late vector wins", int'(vec_idx), 6);
        done();
        chk("R10 displaced request tail-chains", int'(handler_start), 1);
        chk("R10 no restore before displaced", int'(unstacking), 0);
        done();
        wait_quiet();

        // Abandoned restore phase.
        expect_vec(3);
        pulse(0, 0, 8'h01);
        wait_start(n);
        done();
        tick(2);
        expect_vec(7);
        pulse(0, 0, 8'h10);
        wait_start(n);
        chk("R11 start one cycle after record", n, 1);
        chk("R11 restore dropped", int'(unstacking), 0);
        chk("R11 new level", int'(cur_level), 8);
        done();
        wait_quiet();

        // NMI preempts a line; reset beats NMI when both arrive together.
        expect_vec(6);
        pulse(0, 0, 8'h08);
        wait_start(n);
        expect_vec(2);
        pulse(0, 1, 8'h00);
        wait_start(n);
        chk("R1 NMI level", int'(cur_level), 1);
        done();
        wait_quiet();
        chk("R8 NMI returns to line", int'(vec_idx), 6);
        done();
        wait_quiet();
        expect_vec(1);
        expect_vec(2);
        pulse(1, 1, 8'h00);
        wait_start(n);
        chk("R1 reset level", int'(cur_level), 0);
        chk("R2 reset vector", int'(vec_idx), 1);
        done();
        chk("R9 NMI tail-chains after reset", int'(handler_start), 1);
        done();
        wait_quiet();

        // Done with nothing active is ignored.
        done();
        chk("R12 no restore", int'(unstacking), 0);
        tick(1);
        chk("R12 level stays thread", int'(cur_level), 15);
        chk("R12 no vector", int'(vec_valid), 0);

        // Run-time priority change lets line4 preempt line3.
        wr_prio(4, 0);
        expect_vec(6);
        pulse(0, 0, 8'h08);
        wait_start(n);
        expect_vec(7);
        pulse(0, 0, 8'h10);
        wait_start(n);
        chk("R1 reprogrammed level", int'(cur_level), 2);
        done();
        wait_quiet();
        done();
        wait_quiet();

        tick(4);
        chk("R3 all expected starts seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule